// File: doc/BRIEF.md
# Water-Filling Bank Selector for a Departure-Ordered Packet Buffer

This block decides, once per time slot, which of several slow memory banks takes an arriving fixed-size packet. The buffer is built from `3*SLOTS-1` interleaved banks. A bank needs `SLOTS` slots to finish one access. Storage is split into blocks, and each block holds one section per bank. The block keeps an occupancy counter for every (block, bank) pair. An arriving packet carries its departure time. That time picks the block: all packets that leave within the same span of `SECT` frames, each frame being `SLOTS` slots, share one block.

In the arrival slot the block forms a candidate mask. The mask drops banks that are still finishing a recent write and banks that the departure side reports as busy reading. Among the remaining banks it selects the one whose section in the chosen block holds the fewest packets. That counter then goes up by one. The departure side reports each packet it drains from a section, and the matching counter goes down by one. The bank choice is combinational and appears in the same slot as the arrival. All state changes take effect at the clock edge that ends the slot.

Top module: `wf_bank_sel`

## Requirements
- R1: After reset every occupancy counter is zero and no bank is write-blocked, so with no arrival both `sel_valid` and `sel_err` are 0, and the first arrival goes to bank 0.
- R2: An arrival with departure time `t` is placed in block `(t / (SLOTS*SECT)) mod ROWS`.
- R3: A bank whose bit in `rd_busy` is 1 in a slot is never selected in that slot.
- R4: A bank selected in slot `s` is not selectable in slots `s+1` through `s+SLOTS-1`, and becomes selectable again in slot `s+SLOTS`.
- R5: Among the selectable banks, the one with the smallest counter in the addressed block is chosen. Ties go to the lowest bank index.
- R6: A valid selection increments the chosen bank's counter in the addressed block at the end of the slot.
- R7: A drain report (`drain_vld`=1) decrements the counter of block `drain_blk`, bank `drain_bank` by one. A drain report for a counter already at zero has no effect. An increment and a decrement on the same counter in the same slot cancel out.
- R8: If an arrival finds no selectable bank, or the smallest selectable counter already equals `SECT`, then `sel_err`=1 and `sel_valid`=0, and no counter or write-block state changes.
- R9: In a slot with `arr_vld`=0, `sel_valid` and `sel_err` are both 0, and only drains and write-block countdowns change state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_vld | input | 1 | A packet arrives this slot |
| arr_time | input | TW | Departure time of the arriving packet |
| rd_busy | input | 3*SLOTS-1 | Per-bank flag, bank is being read this slot |
| drain_vld | input | 1 | A packet was drained from a section this slot |
| drain_blk | input | clog2(ROWS) | Block of the drained section |
| drain_bank | input | clog2(3*SLOTS-1) | Bank of the drained section |
| sel_valid | output | 1 | `sel_bank` holds a valid choice for this arrival |
| sel_bank | output | clog2(3*SLOTS-1) | Chosen bank |
| sel_blk | output | clog2(ROWS) | Block that the arrival time maps to |
| sel_err | output | 1 | Arrival could not be placed |

## Verification
Back-to-back arrivals into one block check the write-block window and the growth of the counters. With tied counters they show whether the lowest index wins. Departure times chosen on both sides of a block boundary, and beyond the last block, show the block mapping and its wrap. A read-busy mask that covers every bank, and a block filled to capacity, each drive the error path separately. Drains against empty and occupied sections, including a drain that lands on the same counter as a write, separate a saturating decrement from a blind one. Long random traffic with mixed masks and drains is then compared slot by slot against a behavioural model.

// File: rtl/wf_bank_sel.sv
module wf_bank_sel #(
  parameter int SLOTS = 2,
  parameter int ROWS  = 4,
  parameter int SECT  = 4,
  parameter int TW    = 16,
  localparam int K    = 3 * SLOTS - 1,
  localparam int BW   = (K > 1) ? $clog2(K) : 1,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arr_vld,
  input  logic [TW-1:0] arr_time,
  input  logic [K-1:0]  rd_busy,
  input  logic          drain_vld,
  input  logic [RW-1:0] drain_blk,
  input  logic [BW-1:0] drain_bank,
  output logic          sel_valid,
  output logic [BW-1:0] sel_bank,
  output logic [RW-1:0] sel_blk,
  output logic          sel_err
);

  localparam int CW   = $clog2(SECT + 1);
  localparam int WBW  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int SPAN = SLOTS * SECT;

  logic [CW-1:0]  occ   [ROWS][K];
  logic [WBW-1:0] wleft [K];
  logic [K-1:0]   cand;
  logic [CW:0]    best;
  logic [BW-1:0]  pick;
  logic           full;

  assign sel_blk = RW'((arr_time / TW'(SPAN)) % TW'(ROWS));

  for (genvar g = 0; g < K; g++) begin : g_cand
    assign cand[g] = (wleft[g] == '0) && !rd_busy[g];
  end

  always_comb begin
    best = (CW+1)'(SECT + 1);
    pick = '0;
    for (int i = 0; i < K; i++) begin
      if (cand[i] && ({1'b0, occ[sel_blk][i]} < best)) begin
        best = {1'b0, occ[sel_blk][i]};
        pick = BW'(i);
      end
    end
  end

  assign full      = best >= (CW+1)'(SECT);
  assign sel_valid = arr_vld && !full;
  assign sel_err   = arr_vld && full;
  assign sel_bank  = pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < K; i++) wleft[i] <= '0;
    end else begin
      for (int i = 0; i < K; i++) begin
        if (sel_valid && pick == BW'(i)) wleft[i] <= WBW'(SLOTS - 1);
        else if (wleft[i] != '0)         wleft[i] <= wleft[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int i = 0; i < K; i++) occ[r][i] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        for (int i = 0; i < K; i++) begin
          occ[r][i] <= occ[r][i]
            + CW'(sel_valid && sel_blk == RW'(r) && pick == BW'(i))
            - CW'(drain_vld && drain_blk == RW'(r) && drain_bank == BW'(i) && occ[r][i] != '0);
        end
      end
    end
  end

  assert_not_read_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> !rd_busy[sel_bank]);

  if (SLOTS > 1) begin : g_gap
    assert_write_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |=> !(sel_valid && sel_bank == $past(sel_bank)));
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> occ[sel_blk][sel_bank] < CW'(SECT));

  assert_valid_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_valid && sel_err));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_vld |-> (!sel_valid && !sel_err));

  assert_bank_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> int'(sel_bank) < K);

endmodule

// File: tb/tb_wf_bank_sel.sv
module tb_wf_bank_sel;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 2;
  localparam int ROWS  = 4;
  localparam int SECT  = 4;
  localparam int TW    = 16;
  localparam int K     = 3 * SLOTS - 1;
  localparam int BW    = $clog2(K);
  localparam int RW    = $clog2(ROWS);

  logic clk = 0, rst_n = 0;
  logic arr_vld = 0;
  logic [TW-1:0] arr_time = '0;
  logic [K-1:0] rd_busy = '0;
  logic drain_vld = 0;
  logic [RW-1:0] drain_blk = '0;
  logic [BW-1:0] drain_bank = '0;
  logic sel_valid, sel_err;
  logic [BW-1:0] sel_bank;
  logic [RW-1:0] sel_blk;

  int checks = 0, fails = 0;
  int m_occ [ROWS][K];
  int m_wl  [K];

  always #(CLK_PERIOD/2) clk = ~clk;

  wf_bank_sel #(.SLOTS(SLOTS), .ROWS(ROWS), .SECT(SECT), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .arr_vld(arr_vld), .arr_time(arr_time),
    .rd_busy(rd_busy), .drain_vld(drain_vld), .drain_blk(drain_blk),
    .drain_bank(drain_bank), .sel_valid(sel_valid), .sel_bank(sel_bank),
    .sel_blk(sel_blk), .sel_err(sel_err));

  task automatic slot(input bit a, input int t, input logic [K-1:0] rb,
                      input bit dv, input int dr, input int db, input string tag);
    int row, best, bi;
    bit ev, ee, dec;
    @(negedge clk);
    arr_vld = a; arr_time = TW'(t); rd_busy = rb;
    drain_vld = dv; drain_blk = RW'(dr); drain_bank = BW'(db);
    #1;
    row = (t / (SLOTS * SECT)) % ROWS;
    best = SECT + 1; bi = 0;
    for (int i = 0; i < K; i++)
      if (m_wl[i] == 0 && !rb[i] && m_occ[row][i] < best) begin best = m_occ[row][i]; bi = i; end
    ee = a && (best >= SECT);
    ev = a && !ee;
    checks++;
    if (sel_valid !== ev || sel_err !== ee || (ev && (sel_bank !== BW'(bi) || sel_blk !== RW'(row)))) begin
      fails++;
      $display("FAIL %s: valid/bank/blk/err got %0b/%0d/%0d/%0b expected %0b/%0d/%0d/%0b",
               tag, sel_valid, sel_bank, sel_blk, sel_err, ev, bi, row, ee);
    end
    dec = dv && m_occ[dr][db] > 0;
    for (int i = 0; i < K; i++) if (m_wl[i] > 0) m_wl[i]--;
    if (ev) begin m_wl[bi] = SLOTS - 1; m_occ[row][bi]++; end
    if (dec) m_occ[dr][db]--;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R1 watchdog: got no end of run, expected end before limit");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) for (int i = 0; i < K; i++) m_occ[r][i] = 0;
    for (int i = 0; i < K; i++) m_wl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: quiet after reset, first arrival lands in bank 0
    slot(0, 0, '0, 0, 0, 0, "R1");
    slot(1, 0, '0, 0, 0, 0, "R1");
    // R4 and R5: back-to-back arrivals in block 0, gap and tie order
    for (int n = 0; n < 6; n++) slot(1, 3, '0, 0, 0, 0, "R4");
    // R2: boundaries of blocks and wrap beyond the last block
    slot(1, 7, '0, 0, 0, 0, "R2");
    slot(1, 8, '0, 0, 0, 0, "R2");
    slot(1, 17, '0, 0, 0, 0, "R2");
    slot(1, 31, '0, 0, 0, 0, "R2");
    slot(1, 32, '0, 0, 0, 0, "R2");
    slot(1, 100, '0, 0, 0, 0, "R2");
    // R3: read-busy masking
    slot(1, 40, 5'b00011, 0, 0, 0, "R3");
    slot(1, 40, 5'b10101, 0, 0, 0, "R3");
    slot(0, 0, '0, 0, 0, 0, "R9");
    // R8: every bank busy reading
    slot(1, 40, 5'b11111, 0, 0, 0, "R8");
    slot(1, 40, '0, 0, 0, 0, "R5");
    // R6 and R8: fill block 3 to capacity then overflow
    for (int n = 0; n < K * SECT + 2; n++) slot(1, 24, '0, 0, 0, 0, "R8");
    // R7: drains, empty drain, simultaneous write and drain
    slot(0, 0, '0, 1, 2, 4, "R7");
    slot(1, 16, '0, 0, 0, 0, "R7");
    slot(0, 0, '0, 1, 3, 2, "R7");
    slot(1, 24, '0, 1, 3, 1, "R7");
    slot(1, 24, '0, 0, 0, 0, "R7");
    slot(0, 0, '0, 0, 0, 0, "R9");
    slot(1, 24, '0, 0, 0, 0, "R7");
    for (int n = 0; n < 6; n++) slot(0, 0, '0, 1, 3, n % K, "R7");
    for (int n = 0; n < 4; n++) slot(1, 24, '0, 0, 0, 0, "R6");
    // R5: mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [K-1:0] rb;
      for (int i = 0; i < K; i++) rb[i] = ($urandom_range(0, 3) == 0);
      slot($urandom_range(0, 3) != 0, int'($urandom_range(0, 255)), rb,
           $urandom_range(0, 1) == 1, int'($urandom_range(0, ROWS-1)),
           int'($urandom_range(0, K-1)), "R5");
    end
    slot(0, 0, '0, 0, 0, 0, "R9");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule